// File: doc/BRIEF.md
# Synchronous Serial Port Transmitter

This block is the sending half of a synchronous serial port. Software programs it through a small register-style write interface with three addresses: a control word, a clock divisor and a data word. Data words land in a four-entry FIFO. The block then moves each word, in FIFO order, into a shift register and sends it on a serial data pin. The pin is clocked by a serial clock divided down from the system clock. A one-period frame-sync pulse announces each word.

The bit order can be chosen at runtime: most significant bit first or least significant bit first. The driving edge can also be chosen: rising or falling. The word length runs from 3 to 16 bits. The first data write into an enabled, idle port starts the transfer. Words queued behind it then follow without a gap.

A service request stays high while the port is enabled and the FIFO can take another word. A write to a full FIFO is dropped and raises a sticky overflow flag. Clearing the enable bit aborts all activity and empties the FIFO. Reset clears the control word, the divisor and the overflow flag.

Top module: `sstx_port`

## Requirements
- R1: Writes with wr_addr 0 load the control word and wr_addr 1 loads the 8-bit clock divisor. Writes with wr_addr 2 push a data word, and wr_addr 3 is ignored. The control word fields are bit 0 enable, bit 1 LSB-first, bit 2 falling-edge drive and bits 7:4 the word length minus one. Reset clears the control word, the divisor and the overflow flag, so ser_clk, ser_dat, ser_fs, tx_req and ovf_flag all read 0.
- R2: While the port is enabled, ser_clk has a period of 2*(DIV+1) system clock cycles.
- R3: ser_dat and ser_fs change only on the driving edge of ser_clk. With control bit 2 at 0 the driving edge is rising; with bit 2 at 1 it is falling. The receiver samples on the opposite edge. While the port is disabled, ser_clk rests at the value of control bit 2.
- R4: With control bit 1 at 0 each word goes out most significant bit first. With bit 1 at 1 it goes out least significant bit first.
- R5: The word length is the length field plus one. A field value below 2 gives 3 bits, and field 15 gives 16 bits. Bits above the word length are not sent.
- R6: ser_fs is high for exactly one serial clock period, in the bit period just before the first bit of each word. When words follow each other, that period is the last bit of the previous word.
- R7: A data write into an empty FIFO of an enabled port starts a word. ser_fs rises at a driving edge no more than 2*(DIV+1) cycles after the write.
- R8: When the FIFO is empty once a word has finished, ser_dat stays low and ser_fs stays low until new data arrives.
- R9: tx_req is high exactly when the port is enabled and the FIFO holds fewer than 4 words. It follows a write or a pop one cycle later.
- R10: A data write to a full FIFO is dropped and sets ovf_flag. ovf_flag stays set until reset.
- R11: Clearing the enable bit aborts a word in progress. It stops ser_clk at its idle level, drives ser_dat and ser_fs low and empties the FIFO. Data writes while disabled are dropped without setting ovf_flag.
- R12: The FIFO holds 4 words and sends them in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 divisor, 2 data |
| wr_data | input | 16 | Write data |
| ser_clk | output | 1 | Divided serial clock |
| ser_dat | output | 1 | Serial data |
| ser_fs | output | 1 | Frame-sync pulse |
| tx_req | output | 1 | Service request: enabled and FIFO not full |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |

## Verification
tx_req and ovf_flag are due one system cycle after the write or pop that moves them. The bench reads them at the falling system-clock edge after that write. Serial data and frame sync are due at a driving edge of ser_clk, which comes at most 2*(DIV+1) cycles after the FIFO fills. The bench therefore recovers words by sampling at the opposite serial edge instead of counting cycles. It counts the cycles between driving edges and between a write and the rising frame sync, and compares them with the divisor-derived bound.

// File: rtl/sstx_pkg.sv
// Shared register addresses and control-word bit positions for the serial
// transmitter. Assumes a 2-bit register address.
package sstx_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam int CTL_EN     = 0;
    localparam int CTL_LSB    = 1;
    localparam int CTL_FALL   = 2;
    localparam int CTL_LEN_LO = 4;
endpackage

// File: rtl/sstx_fifo.sv
// Word FIFO for the transmitter. A push when full and a pop when empty are
// ignored. The head word is read combinationally. A flush empties the FIFO
// synchronously.
module sstx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/sstx_clkgen.sv
// Serial clock generator. While run is high, it toggles a phase every DIV+1
// system cycles. drv_tick marks the system cycle whose edge makes the
// driving transition. The output edge sense is set by inverting the phase.
// Assumes run low holds the generator at rest.
module sstx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             fall_drive,
    output logic             drv_tick,
    output logic             ser_clk
);
    logic [DIV_W-1:0] cnt;
    logic             ph;

    assign drv_tick = run && (cnt == div) && !ph;
    assign ser_clk  = ph ^ fall_drive;

    // Count out the half period and toggle the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (cnt == div) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        drv_tick |=> !drv_tick);
    a_r11_rest_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ph == 1'b0));
endmodule

// File: rtl/sstx_shifter.sv
// Transmit shift engine. On each driving tick it either sends the next bit
// or, when idle, drives the line low. It loads a new word from the FIFO
// head during the last bit or the idle period, and raises frame sync for
// that period. MSB-first words are left-aligned at load. The bit order is
// latched per word.
module sstx_shifter #(
    parameter int W     = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             drv_tick,
    input  logic             lsb_first,
    input  logic [LEN_W-1:0] word_len,
    input  logic             fifo_empty,
    input  logic [W-1:0]     fifo_dout,
    output logic             pop,
    output logic             ser_dat,
    output logic             ser_fs
);
    logic [W-1:0]     sh;
    logic [LEN_W-1:0] rem;
    logic             ord_lsb;
    logic             cur_bit;
    logic             load_slot;
    logic [W-1:0]     load_val;

    assign cur_bit   = ord_lsb ? sh[0] : sh[W-1];
    assign load_slot = (rem == '0) || (rem == LEN_W'(1));
    assign pop       = drv_tick && !fifo_empty && load_slot;
    assign load_val  = lsb_first ? fifo_dout
                                 : (fifo_dout << (LEN_W'(W) - word_len));

    // Send bits, load words and frame them on each driving tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sh      <= '0;
            rem     <= '0;
            ord_lsb <= 1'b0;
            ser_dat <= 1'b0;
            ser_fs  <= 1'b0;
        end else if (drv_tick) begin
            ser_dat <= (rem != '0) ? cur_bit : 1'b0;
            if (pop) begin
                sh      <= load_val;
                ord_lsb <= lsb_first;
                rem     <= word_len;
                ser_fs  <= 1'b1;
            end else begin
                ser_fs <= 1'b0;
                if (rem != '0) begin
                    sh  <= ord_lsb ? (sh >> 1) : (sh << 1);
                    rem <= rem - 1'b1;
                end
            end
        end
    end

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !drv_tick) |=> ($stable(ser_dat) && $stable(ser_fs)));
endmodule

// File: rtl/sstx_port.sv
// Synchronous serial transmitter top. It holds the control and divisor
// registers and the sticky overflow flag, and connects the FIFO, clock
// generator and shift engine. Assumes software does not change the
// mode bits while enabled.
module sstx_port #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              ser_fs,
    output logic              tx_req,
    output logic              ovf_flag
);
    import sstx_pkg::*;

    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int LENF_W = $clog2(DATA_W);

    logic              ctl_en, ctl_lsb, ctl_fall;
    logic [LENF_W-1:0] ctl_lenf;
    logic [DIV_W-1:0]  div_q;
    logic              ovf_q;
    logic [LEN_W-1:0]  word_len;
    logic              data_wr, fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [DATA_W-1:0] fifo_dout;
    logic              drv_tick;

    assign data_wr   = wr_en && (wr_addr == ADDR_DATA);
    assign fifo_push = data_wr && ctl_en;
    assign tx_req    = ctl_en && !fifo_full;
    assign ovf_flag  = ovf_q;

    // Word length from the field, with short settings clamped to 3 bits.
    always_comb begin
        if (ctl_lenf < LENF_W'(2)) word_len = LEN_W'(3);
        else                       word_len = LEN_W'(ctl_lenf) + 1'b1;
    end

    // Load the control and divisor registers from the write interface.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_lsb  <= 1'b0;
            ctl_fall <= 1'b0;
            ctl_lenf <= '0;
            div_q    <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctl_en   <= wr_data[CTL_EN];
            ctl_lsb  <= wr_data[CTL_LSB];
            ctl_fall <= wr_data[CTL_FALL];
            ctl_lenf <= wr_data[CTL_LEN_LO +: LENF_W];
        end else if (wr_en && wr_addr == ADDR_DIV) begin
            div_q    <= wr_data[DIV_W-1:0];
        end
    end

    // Latch a dropped write to a full FIFO until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_q <= 1'b0;
        else if (fifo_push && fifo_full) ovf_q <= 1'b1;
    end

    sstx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!ctl_en),
        .push(fifo_push), .din(wr_data), .pop(fifo_pop),
        .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
    );

    sstx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(ctl_en), .div(div_q),
        .fall_drive(ctl_fall), .drv_tick(drv_tick), .ser_clk(ser_clk)
    );

    sstx_shifter #(.W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(ctl_en), .drv_tick(drv_tick),
        .lsb_first(ctl_lsb), .word_len(word_len),
        .fifo_empty(fifo_empty), .fifo_dout(fifo_dout),
        .pop(fifo_pop), .ser_dat(ser_dat), .ser_fs(ser_fs)
    );

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (!ser_fs && !ser_dat));
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
endmodule

// File: tb/sstx_port_tb.sv
// Sweeps divisor, length, bit order and driving edge, recovering words at
// the sampling edge. Then exercises overflow, abort and reset.
module sstx_port_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ser_clk, ser_dat, ser_fs, tx_req, ovf_flag;

    int n_checks = 0, n_fail = 0, cyc = 0;
    // monitor state
    bit mon_on = 0, m_fall = 0, m_lsb = 0, have_last = 0;
    int m_len = 8, m_div = 0, rem = 0, acc = 0, frames = 0, last_drv = 0;
    int err_per = 0, err_edge = 0, err_fs = 0, err_idle = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;
    int exp_w [0:255];
    int wr_i = 0, rd_i = 0;

    always #(CLK_P/2) clk = ~clk;

    sstx_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_fs(ser_fs), .tx_req(tx_req), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_word(input int w);
        exp_w[wr_i] = w;
        wr_i++;
        wr(2'd2, 16'(w));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Serial receiver: driving edge timing and sampling edge capture.
    always @(negedge clk) begin
        if (mon_on) begin
            if (ser_clk != prev_clk && ser_clk == !m_fall) begin
                if (have_last && (cyc - last_drv) != 2 * (m_div + 1)) err_per++;
                last_drv = cyc;
                have_last = 1;
            end else begin
                if (ser_dat != prev_dat) err_edge++;
                if (ser_clk != prev_clk) begin
                    if (rem > 0) begin
                        if (ser_fs && rem != 1) err_fs++;
                        if (m_lsb) acc = acc | (int'(ser_dat) << (m_len - rem));
                        else       acc = (acc << 1) | int'(ser_dat);
                        rem--;
                        if (rem == 0) begin
                            check(acc == exp_w[rd_i], "R4 R5 R12 word", acc, exp_w[rd_i]);
                            rd_i++;
                            frames++;
                        end
                    end else if (ser_dat) begin
                        err_idle++;
                    end
                    if (ser_fs) begin
                        rem = m_len;
                        acc = 0;
                    end
                end
            end
        end
        prev_clk = ser_clk;
        prev_dat = ser_dat;
    end

    task automatic mon_start(input int d, input int len, input bit lsb, input bit fall);
        m_div = d; m_len = len; m_lsb = lsb; m_fall = fall;
        rem = 0; acc = 0; frames = 0; have_last = 0;
        err_per = 0; err_edge = 0; err_fs = 0; err_idle = 0;
        rd_i = wr_i;
        mon_on = 1;
    endtask

    task automatic wait_frames(input int n);
        for (int k = 0; k < 4000 && frames < n; k++) @(negedge clk);
    endtask

    initial begin
        int lenf [3];
        int lens [3];
        int seed;
        lenf = '{0, 7, 15};
        lens = '{3, 8, 16};
        seed = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ser_clk == 0 && ser_dat == 0 && ser_fs == 0, "R1 reset serial outputs",
              {ser_clk, ser_dat, ser_fs}, 0);
        check(tx_req == 0 && ovf_flag == 0, "R1 reset req/ovf", {tx_req, ovf_flag}, 0);

        for (int d = 0; d < 3; d++)
          for (int li = 0; li < 3; li++)
            for (int o = 0; o < 2; o++)
              for (int f = 0; f < 2; f++) begin
                  int mask, n;
                  mon_on = 0;
                  wr(2'd0, 16'((f << 2) | (o << 1)));
                  wr(2'd1, 16'(d));
                  repeat (2) @(negedge clk);
                  check(ser_clk == f, "R3 idle clock level", ser_clk, f);
                  mask = (1 << lens[li]) - 1;
                  mon_start(d, lens[li], o[0], f[0]);
                  wr(2'd0, 16'((lenf[li] << 4) | (f << 2) | (o << 1) | 1));
                  push_word(((seed * 40503) ^ 23100) & mask); seed++;
                  push_word(((seed * 40503) ^ 23100) & mask); seed++;
                  wait_frames(2);
                  repeat (6 * (d + 1)) @(negedge clk);
                  check(ser_fs == 0 && ser_dat == 0, "R8 idle after empty",
                        {ser_fs, ser_dat}, 0);
                  push_word(((seed * 40503) ^ 23100) & mask); seed++;
                  n = 0;
                  while (!ser_fs && n < 100) begin @(negedge clk); n++; end
                  check(n <= 2 * (d + 1), "R7 start latency", n, 2 * (d + 1));
                  wait_frames(3);
                  repeat (4 * (d + 1)) @(negedge clk);
                  check(frames == 3, "R6 frame count", frames, 3);
                  check(err_fs == 0, "R6 frame sync placement", err_fs, 0);
                  check(err_per == 0, "R2 serial clock period", err_per, 0);
                  check(err_edge == 0, "R3 change only on driving edge", err_edge, 0);
                  check(err_idle == 0, "R8 data low when idle", err_idle, 0);
              end

        // Overflow, request and abort (R9 R10 R11 R12)
        mon_on = 0;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd40);
        check(tx_req == 0, "R9 req low when disabled", tx_req, 0);
        wr(2'd0, 16'h0071);
        check(tx_req == 1, "R9 req high enabled empty", tx_req, 1);
        for (int k = 0; k < 3; k++) wr(2'd2, 16'(k + 5));
        check(tx_req == 1, "R12 room after 3 words", tx_req, 1);
        wr(2'd2, 16'h00AA);
        check(tx_req == 0 && ovf_flag == 0, "R9 R12 full at 4 words", {tx_req, ovf_flag}, 0);
        wr(2'd2, 16'h00BB);
        check(ovf_flag == 1, "R10 overflow set", ovf_flag, 1);
        check(tx_req == 0, "R10 dropped write keeps full", tx_req, 0);
        for (int k = 0; k < 200 && !ser_fs; k++) @(negedge clk);
        @(negedge clk);
        check(tx_req == 1, "R9 req after pop", tx_req, 1);
        repeat (300) @(negedge clk);
        wr(2'd0, 16'h0070);
        check(ser_clk == 0 && ser_dat == 0 && ser_fs == 0, "R11 abort quiet",
              {ser_clk, ser_dat, ser_fs}, 0);
        check(tx_req == 0 && ovf_flag == 1, "R10 R11 sticky and req low",
              {tx_req, ovf_flag}, 1);
        wr(2'd2, 16'h0055);
        wr(2'd3, 16'h0001);
        check(ser_dat == 0 && tx_req == 0, "R1 R11 ignored writes", {ser_dat, tx_req}, 0);
        wr(2'd0, 16'h0071);
        check(tx_req == 1, "R11 FIFO flushed", tx_req, 1);
        begin
            int seen = 0;
            for (int k = 0; k < 300; k++) begin @(negedge clk); if (ser_fs) seen++; end
            check(seen == 0, "R11 nothing sent after re-enable", seen, 0);
        end
        check(ovf_flag == 1, "R10 flag survives enable", ovf_flag, 1);

        // Reset clears divisor and control (R1)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ovf_flag == 0 && tx_req == 0, "R1 R10 reset clears", {ovf_flag, tx_req}, 0);
        mon_start(0, 3, 0, 0);
        wr(2'd0, 16'h0001);
        push_word(5);
        wait_frames(1);
        repeat (4) @(negedge clk);
        check(frames == 1 && err_per == 0, "R1 R2 divisor cleared to 0", err_per, 0);
        mon_on = 0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule